// File: doc/BRIEF.md
# Master-Mode Serial Audio Clock Generator

This block produces the serial audio timing clocks when the device drives the audio bus as clock master. It runs from a system clock at 256 times the maximum sample rate and divides it down into a bit clock, a frame (left/right) clock and a one-cycle frame-start strobe. It also passes the system clock through as a gated master clock for converters.

The bit clock runs at 32 or 64 times the frame rate. A slow-rate option runs the frame at two thirds of the full rate, so one frame spans 384 system clocks instead of 256. The level of the frame clock in the first half of each frame follows the chosen format: low for I2S, high for the justified formats. Ratio, rate and format selections are taken up only at a frame boundary, so a change never produces a shortened clock pulse.

When the master enable is low, the bit clock, frame clock and strobe stay low. A frame begins on the cycle after the enable is first sampled high.

Top module: `audio_clk_master`

## Requirements
- R1: While `master_en` is low (sampled at the previous clock edge) or reset is asserted, `bck_o`, `lrck_o` and `frame_start_o` are all low.
- R2: With `wide_sel`=1 and `slow_sel`=0, `bck_o` has a period of 4 system clocks: 2 cycles low, then 2 cycles high.
- R3: With `wide_sel`=0 and `slow_sel`=0, `bck_o` has a period of 8 system clocks: 4 cycles low, then 4 cycles high.
- R4: With `slow_sel`=1, `bck_o` has a period of 6 system clocks (`wide_sel`=1) or 12 system clocks (`wide_sel`=0), low for the first half of the period. One frame lasts 384 system clocks.
- R5: One frame holds 64 bit-clock periods (`wide_sel`=1) or 32 (`wide_sel`=0). `lrck_o` toggles after half of them and again at the frame end, so a full-rate frame lasts 256 system clocks.
- R6: `lrck_o` is low during the first half of a frame when `i2s_sel`=1, and high during the first half when `i2s_sel`=0.
- R7: `lrck_o` changes only in a cycle where `bck_o` goes from high to low.
- R8: `frame_start_o` is high for exactly the first system-clock cycle of each frame. In that cycle `bck_o` is low.
- R9: Values of `wide_sel`, `slow_sel` and `i2s_sel` that change during a frame take effect at the start of the next frame.
- R10: `mclk_o` follows `clk` while `mclk_en` is high and stays low while `mclk_en` is low.
- R11: After `master_en` is sampled high from the stopped state, the following cycle is the first cycle of a frame: `frame_start_o` is high, and `bck_o` is low for its first half period.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, 256 times the full sample rate |
| rst_n | input | 1 | Active-low synchronous reset |
| master_en | input | 1 | Enables generation of the bit and frame clocks |
| wide_sel | input | 1 | 1: 64 bit clocks per frame, 0: 32 |
| slow_sel | input | 1 | 1: frame rate is two thirds of the full rate |
| i2s_sel | input | 1 | 1: frame clock low in the first half (I2S), 0: high (justified) |
| mclk_en | input | 1 | Enables the master clock output |
| bck_o | output | 1 | Bit clock |
| lrck_o | output | 1 | Frame (left/right) clock |
| mclk_o | output | 1 | Gated copy of the system clock |
| frame_start_o | output | 1 | One-cycle strobe at the start of each frame |

## Verification
The embedded properties assume two things. The selection inputs are synchronous to `clk`. Reset is asserted from time zero, so every history a property reads starts in a known state. The bench drives every input on the falling clock edge, so nothing changes at an active edge. It changes selections only while the last expected frame is in progress, which makes the expected boundary at which a new setting applies unambiguous. The enable is dropped and raised again only after all expected items have been compared, so each restart is checked from its first frame cycle.

// File: rtl/audio_clk_master.sv
module audio_clk_master #(
  parameter int BASE_DIV  = 4,
  parameter int WIDE_BITS = 64
) (
  input  logic clk,
  input  logic rst_n,
  input  logic master_en,
  input  logic wide_sel,
  input  logic slow_sel,
  input  logic i2s_sel,
  input  logic mclk_en,
  output logic bck_o,
  output logic lrck_o,
  output logic mclk_o,
  output logic frame_start_o
);
  localparam int NARROW_BITS = WIDE_BITS / 2;
  localparam int SLOW_DIV    = BASE_DIV * 3 / 2;
  localparam int MAX_DIV     = 2 * SLOW_DIV;
  localparam int PW          = $clog2(MAX_DIV);
  localparam int BW          = $clog2(WIDE_BITS);

  logic          run;
  logic          wide_q, slow_q, i2s_q;
  logic [PW-1:0] ph;
  logic [BW-1:0] bitn;
  logic [PW-1:0] div, half;
  logic [BW-1:0] last_bit, half_bits;
  logic          bit_end, frame_end;

  // divider per setting: BASE_DIV must be a multiple of 4 for even halves
  always_comb begin
    case ({wide_q, slow_q})
      2'b10:   div = PW'(BASE_DIV);
      2'b11:   div = PW'(SLOW_DIV);
      2'b00:   div = PW'(2 * BASE_DIV);
      default: div = PW'(MAX_DIV);
    endcase
  end

  assign half      = div >> 1;
  assign last_bit  = wide_q ? BW'(WIDE_BITS - 1) : BW'(NARROW_BITS - 1);
  assign half_bits = wide_q ? BW'(WIDE_BITS / 2) : BW'(NARROW_BITS / 2);
  assign bit_end   = (ph == div - PW'(1));
  assign frame_end = run && bit_end && (bitn == last_bit);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      run    <= 1'b0;
      ph     <= '0;
      bitn   <= '0;
      wide_q <= 1'b1;
      slow_q <= 1'b0;
      i2s_q  <= 1'b1;
    end else if (!master_en) begin
      run  <= 1'b0;
      ph   <= '0;
      bitn <= '0;
    end else if (!run || frame_end) begin
      run    <= 1'b1;
      ph     <= '0;
      bitn   <= '0;
      wide_q <= wide_sel;
      slow_q <= slow_sel;
      i2s_q  <= i2s_sel;
    end else if (bit_end) begin
      ph   <= '0;
      bitn <= bitn + BW'(1);
    end else begin
      ph <= ph + PW'(1);
    end
  end

  assign bck_o         = run && (ph >= half);
  assign lrck_o        = run && ((bitn < half_bits) ? !i2s_q : i2s_q);
  assign frame_start_o = run && (ph == '0) && (bitn == '0);
  assign mclk_o        = clk & mclk_en;

  a_r1_idle_low: assert property (@(posedge clk) disable iff (!rst_n)
    !master_en |=> (!bck_o && !lrck_o && !frame_start_o));

  a_r7_lr_on_bck_fall: assert property (@(posedge clk) disable iff (!rst_n)
    (run && $past(run) && (lrck_o != $past(lrck_o))) |-> ($past(bck_o) && !bck_o));

  a_r8_start_single: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start_o |=> !frame_start_o);

  a_r8_start_bck_low: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start_o |-> !bck_o);

  a_r9_cfg_held: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !frame_end) |=> ($stable(wide_q) && $stable(slow_q) && $stable(i2s_q)));
endmodule

// File: tb/test_audio_clk_master.sv
module test_audio_clk_master;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic master_en = 1'b0, wide_sel = 1'b1, slow_sel = 1'b0, i2s_sel = 1'b1, mclk_en = 1'b0;
  logic bck_o, lrck_o, mclk_o, frame_start_o;
  int errors = 0, checks = 0;
  bit done = 1'b0;

  typedef struct { bit bck; bit lr; bit fs; string tag; } item_t;
  item_t q[$];

  always #2 clk = ~clk;

  audio_clk_master i_audio_clk_master (
    .clk(clk), .rst_n(rst_n), .master_en(master_en), .wide_sel(wide_sel),
    .slow_sel(slow_sel), .i2s_sel(i2s_sel), .mclk_en(mclk_en),
    .bck_o(bck_o), .lrck_o(lrck_o), .mclk_o(mclk_o), .frame_start_o(frame_start_o));

  task automatic check(input bit got, input bit exp, input string req, input string what);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s %s got %b expected %b at %0t", req, what, got, exp, $time);
    end
  endtask

  // expected frame built from the requirement text: bck low for first half of each
  // bit period (R2, R3, R4), lr level per half frame (R5, R6), strobe on cycle 0 (R8)
  task automatic push_frames(input bit w, input bit s, input bit i, input int nf, input string tag);
    int dv = w ? (s ? 6 : 4) : (s ? 12 : 8);
    int bits = w ? 64 : 32;
    for (int f = 0; f < nf; f++)
      for (int n = 0; n < dv * bits; n++) begin
        item_t e;
        e.bck = (n % dv) >= dv / 2;
        e.lr  = ((n / dv) < bits / 2) ? !i : i;
        e.fs  = (n == 0);
        e.tag = tag;
        q.push_back(e);
      end
  endtask

  // monitor: compares one expected item per cycle, sampled 1 ns after the edge
  always begin
    item_t e;
    @(posedge clk); #1;
    if (q.size() > 0) begin
      e = q.pop_front();
      check(bck_o, e.bck, e.tag, "bck_o");
      check(lrck_o, e.lr, "R5/R6", "lrck_o");
      check(frame_start_o, e.fs, "R8", "frame_start_o");
    end
  end

  task automatic wait_last(input int len);
    @(negedge clk);
    while (!(q.size() > 0 && q.size() < len)) @(negedge clk);
  endtask

  task automatic wait_empty();
    @(negedge clk);
    while (q.size() > 0) @(negedge clk);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    #200000;
    errors++;
    $display("FAIL R1 watchdog got timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    check(bck_o, 1'b0, "R1", "reset bck_o");
    check(lrck_o, 1'b0, "R1", "reset lrck_o");
    check(frame_start_o, 1'b0, "R1", "reset frame_start_o");
    @(negedge clk); rst_n = 1'b1;
    repeat (2) @(posedge clk);
    #1;
    check(lrck_o | bck_o | frame_start_o, 1'b0, "R1", "idle outputs");

    // R11: start, 64fs full rate, I2S
    @(negedge clk);
    wide_sel = 1'b1; slow_sel = 1'b0; i2s_sel = 1'b1; master_en = 1'b1;
    push_frames(1, 0, 1, 1, "R11");
    push_frames(1, 0, 1, 1, "R2");

    // R9: change mid frame to 32fs, justified; applies at next boundary
    wait_last(256);
    wide_sel = 1'b0; i2s_sel = 1'b0;
    push_frames(0, 0, 0, 1, "R9");
    push_frames(0, 0, 0, 1, "R3");

    wait_last(256);
    wide_sel = 1'b1; slow_sel = 1'b1; i2s_sel = 1'b0;
    push_frames(1, 1, 0, 1, "R4");

    wait_last(384);
    wide_sel = 1'b0; slow_sel = 1'b1; i2s_sel = 1'b1;
    push_frames(0, 1, 1, 2, "R4");

    // R1: disable stops everything on the next cycle
    wait_empty();
    master_en = 1'b0;
    for (int k = 0; k < 5; k++) begin
      @(posedge clk); #1;
      check(bck_o, 1'b0, "R1", "disabled bck_o");
      check(lrck_o, 1'b0, "R1", "disabled lrck_o");
      check(frame_start_o, 1'b0, "R1", "disabled frame_start_o");
    end

    // R11: restart, R7 guarded by a_r7_lr_on_bck_fall throughout
    @(negedge clk);
    wide_sel = 1'b1; slow_sel = 1'b0; i2s_sel = 1'b0; master_en = 1'b1;
    push_frames(1, 0, 0, 1, "R11");
    wait_empty();

    // R10: master clock gating
    mclk_en = 1'b1;
    for (int k = 0; k < 3; k++) begin
      @(posedge clk); #1; check(mclk_o, 1'b1, "R10", "mclk_o high phase");
      @(negedge clk); #1; check(mclk_o, 1'b0, "R10", "mclk_o low phase");
    end
    @(negedge clk); mclk_en = 1'b0;
    for (int k = 0; k < 3; k++) begin
      @(posedge clk); #1; check(mclk_o, 1'b0, "R10", "mclk_o gated");
    end
    finish_run();
  end
endmodule